// File: doc/BRIEF.md
# 4B5B Transmit Encoder with Error Injection

This block sits between a media-independent transmit interface and a 100BASE-X serializer. Every transmit clock it samples a 4-bit nibble, an enable and an error flag, and one cycle later it presents one 5-bit code group. Each nibble inside a frame is mapped through the standard 4B5B table. The first two nibbles of a frame are replaced by the start delimiter pair. The two cycles after the frame end carry the end delimiter pair. The line idles between frames.

The error flag normally replaces the current data nibble with a HALT code group. When the test input is set, the error flag becomes the fifth encoder input instead. With it high, each nibble value selects one of the sixteen code groups that carry no data. All 32 code groups can then be placed on the line, so a receiver's invalid-symbol handling can be tested.

Top module: `tx4b5b_encoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `code_out` is IDLE (11111).
- R2: Outside a frame and outside the end delimiter, `code_out` is IDLE. `tx_nibble`, `tx_err` and `test_mode` have no effect there.
- R3: The code group for the inputs sampled at rising edge k appears after edge k and stays until edge k+1. Latency is exactly one cycle.
- R4: The first cycle with `tx_en` high after idle emits J (11000), and the second emits K (10001), whatever the nibble and error inputs are.
- R5: The first cycle with `tx_en` low after a frame emits T (01101), and the next emits R (00111). This holds for a one-nibble frame too. `tx_en` sampled high in the R cycle is ignored: R is still sent, and a frame starts with J on the following cycle if `tx_en` is still high.
- R6: A data cycle (third or later cycle with `tx_en` high) with `tx_err` low maps the nibble, bit 0 least significant, as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R7: With `test_mode` low, every data cycle with `tx_err` high emits HALT (00100), one per cycle, and a burst of consecutive error cycles gives a run of HALTs. `tx_err` in a J or K cycle has no effect.
- R8: With `test_mode` high, a data cycle with `tx_err` high emits the n-th code group not in the R6 table, counted in ascending order, where n is the nibble. The list is 00000, 00001, 00010, 00011, 00100, 00101, 00110, 00111, 01000, 01100, 01101, 10000, 10001, 11000, 11001, 11111. With `tx_err` low, the R6 table applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Makes the error flag the fifth encoder input |
| tx_en | input | 1 | Frame enable, high while nibbles are valid |
| tx_err | input | 1 | Error flag for the current nibble |
| tx_nibble | input | 4 | Transmit nibble, bit 0 least significant |
| code_out | output | 5 | Registered 5-bit code group |

## Verification
The hardest case is `tx_en` rising again during the R cycle, just one low cycle after a frame ends. Random frames are separated by gaps of one to five low cycles, so this case happens often, and the bench model must still expect R before the new J. A directed frame in test mode steps through all 32 values of error flag and nibble, so every code group, including J, K, T, R and IDLE, appears as data. These lookalikes check that delimiter sequencing is driven by the frame phase and never by the last code group sent.

// File: rtl/tx4b5b_pkg.sv
package tx4b5b_pkg;

   localparam logic [4:0] CG_IDLE = 5'b11111;
   localparam logic [4:0] CG_J    = 5'b11000;
   localparam logic [4:0] CG_K    = 5'b10001;
   localparam logic [4:0] CG_T    = 5'b01101;
   localparam logic [4:0] CG_R    = 5'b00111;
   localparam logic [4:0] CG_HALT = 5'b00100;

   // frame phase held between cycles
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_K    = 2'd1,
      PH_DATA = 2'd2,
      PH_R    = 2'd3
   } frame_phase_e;

   // what the current cycle emits
   typedef enum logic [2:0] {
      SEL_IDLE = 3'd0,
      SEL_J    = 3'd1,
      SEL_K    = 3'd2,
      SEL_DATA = 3'd3,
      SEL_T    = 3'd4,
      SEL_R    = 3'd5
   } code_sel_e;

   function automatic logic [4:0] data_group(input logic [3:0] nib);
      logic [4:0] g;
      case (nib)
         4'h0: g = 5'b11110;
         4'h1: g = 5'b01001;
         4'h2: g = 5'b10100;
         4'h3: g = 5'b10101;
         4'h4: g = 5'b01010;
         4'h5: g = 5'b01011;
         4'h6: g = 5'b01110;
         4'h7: g = 5'b01111;
         4'h8: g = 5'b10010;
         4'h9: g = 5'b10011;
         4'hA: g = 5'b10110;
         4'hB: g = 5'b10111;
         4'hC: g = 5'b11010;
         4'hD: g = 5'b11011;
         4'hE: g = 5'b11100;
         default: g = 5'b11101;
      endcase
      return g;
   endfunction

   function automatic logic is_data_group(input logic [4:0] g);
      logic hit;
      hit = 1'b0;
      for (int n = 0; n < 16; n++) begin
         if (data_group(4'(n)) == g) hit = 1'b1;
      end
      return hit;
   endfunction

   // n-th non-data code group in ascending order
   function automatic logic [4:0] spare_group(input logic [3:0] idx);
      logic [4:0] res;
      int         cnt;
      res = 5'b0;
      cnt = 0;
      for (int v = 0; v < 32; v++) begin
         if (!is_data_group(5'(v))) begin
            if (cnt == int'(idx)) res = 5'(v);
            cnt++;
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/tx4b5b_frame_ctl.sv
module tx4b5b_frame_ctl
   import tx4b5b_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tx_en,
   output frame_phase_e phase,
   output code_sel_e    sel
);

   frame_phase_e phase_q, phase_d;
   code_sel_e    sel_d;

   always_comb begin
      phase_d = phase_q;
      sel_d   = SEL_IDLE;
      case (phase_q)
         PH_IDLE: begin
            if (tx_en) begin
               sel_d   = SEL_J;
               phase_d = PH_K;
            end
         end
         PH_K: begin
            if (tx_en) begin
               sel_d   = SEL_K;
               phase_d = PH_DATA;
            end else begin
               sel_d   = SEL_T;
               phase_d = PH_R;
            end
         end
         PH_DATA: begin
            if (tx_en) begin
               sel_d   = SEL_DATA;
            end else begin
               sel_d   = SEL_T;
               phase_d = PH_R;
            end
         end
         default: begin
            sel_d   = SEL_R;
            phase_d = PH_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   assign phase = phase_q;
   assign sel   = sel_d;

   // R5: the end delimiter always leads back to idle
   assert_r_returns_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_R) |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/tx4b5b_code_map.sv
module tx4b5b_code_map
   import tx4b5b_pkg::*;
#(
   parameter bit TEST_MODE_EN = 1'b1
)(
   input  code_sel_e   sel,
   input  logic [3:0]  tx_nibble,
   input  logic        tx_err,
   input  logic        test_mode,
   output logic [4:0]  code
);

   logic test_eff;

   generate
      if (TEST_MODE_EN) begin : g_test
         assign test_eff = test_mode;
      end else begin : g_no_test
         assign test_eff = 1'b0;
      end
   endgenerate

   logic [4:0] data_code;

   always_comb begin
      if (test_eff) data_code = tx_err ? spare_group(tx_nibble) : data_group(tx_nibble);
      else          data_code = tx_err ? CG_HALT : data_group(tx_nibble);
   end

   always_comb begin
      case (sel)
         SEL_J:    code = CG_J;
         SEL_K:    code = CG_K;
         SEL_T:    code = CG_T;
         SEL_R:    code = CG_R;
         SEL_DATA: code = data_code;
         default:  code = CG_IDLE;
      endcase
   end

   // R6: a clean data nibble never maps onto a control group
   always_comb begin
      if (sel == SEL_DATA && !tx_err) begin
         assert_data_not_control_R6: assert (code != CG_IDLE && code != CG_HALT
                                             && code != CG_J && code != CG_T);
      end
   end

endmodule

// File: rtl/tx4b5b_encoder.sv
module tx4b5b_encoder
   import tx4b5b_pkg::*;
#(
   parameter int NIBBLE_W     = 4,
   parameter int CODE_W       = 5,
   parameter bit TEST_MODE_EN = 1'b1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                test_mode,
   input  logic                tx_en,
   input  logic                tx_err,
   input  logic [NIBBLE_W-1:0] tx_nibble,
   output logic [CODE_W-1:0]   code_out
);

   localparam int INDEX_W = NIBBLE_W + 1;

   generate
      if (NIBBLE_W != 4) begin : g_bad_nibble
         $error("tx4b5b_encoder: NIBBLE_W must be 4");
      end
      if (CODE_W != INDEX_W) begin : g_bad_code
         $error("tx4b5b_encoder: CODE_W must be NIBBLE_W + 1");
      end
   endgenerate

   frame_phase_e phase;
   code_sel_e    sel;
   logic [4:0]   code_d;

   tx4b5b_frame_ctl i_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .tx_en (tx_en),
      .phase (phase),
      .sel   (sel)
   );

   tx4b5b_code_map #(.TEST_MODE_EN(TEST_MODE_EN)) i_map (
      .sel       (sel),
      .tx_nibble (tx_nibble[3:0]),
      .tx_err    (tx_err),
      .test_mode (test_mode),
      .code      (code_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_out <= CODE_W'(CG_IDLE);
      else        code_out <= CODE_W'(code_d);
   end

   assert_idle_when_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && !tx_en) |=> (code_out == CODE_W'(CG_IDLE)));

   assert_j_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && tx_en) |=> (code_out == CODE_W'(CG_J)));

   assert_k_after_j_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_K && tx_en) |=> (code_out == CODE_W'(CG_K)));

   assert_t_on_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA && !tx_en) |=> (code_out == CODE_W'(CG_T)));

   assert_r_after_t_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_R) |=> (code_out == CODE_W'(CG_R)));

   assert_halt_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA && tx_en && tx_err && !test_mode) |=> (code_out == CODE_W'(CG_HALT)));

endmodule

// File: tb/test_tx4b5b_encoder.sv
module test_tx4b5b_encoder;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       test_mode;
   logic       tx_en;
   logic       tx_err;
   logic [3:0] tx_nibble;
   logic [4:0] code_out;

   always #4 clk = ~clk;

   tx4b5b_encoder i_tx4b5b_encoder (
      .clk       (clk),
      .rst_n     (rst_n),
      .test_mode (test_mode),
      .tx_en     (tx_en),
      .tx_err    (tx_err),
      .tx_nibble (tx_nibble),
      .code_out  (code_out)
   );

   int         n_cmp = 0;
   int         n_bad = 0;
   int         m_ph  = 0;
   logic [4:0] exp_code;
   string      exp_req;
   bit         have_exp = 1'b0;
   bit         done = 1'b0;

   function automatic logic [4:0] ref_data(input logic [3:0] n);
      logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                             5'b01010, 5'b01011, 5'b01110, 5'b01111,
                             5'b10010, 5'b10011, 5'b10110, 5'b10111,
                             5'b11010, 5'b11011, 5'b11100, 5'b11101};
      return t[n];
   endfunction

   function automatic logic [4:0] ref_spare(input logic [3:0] n);
      logic [4:0] t [16] = '{5'b00000, 5'b00001, 5'b00010, 5'b00011,
                             5'b00100, 5'b00101, 5'b00110, 5'b00111,
                             5'b01000, 5'b01100, 5'b01101, 5'b10000,
                             5'b10001, 5'b11000, 5'b11001, 5'b11111};
      return t[n];
   endfunction

   task automatic check(input logic [4:0] act, input logic [4:0] exp, input string req);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: code_out=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // expected output for inputs sampled at the coming edge
   task automatic model(input bit en, input bit err, input logic [3:0] nib, input bit tm);
      case (m_ph)
         0: if (en) begin exp_code = 5'b11000; exp_req = "R4"; m_ph = 1; end
            else    begin exp_code = 5'b11111; exp_req = "R2"; end
         1: if (en) begin exp_code = 5'b10001; exp_req = "R4"; m_ph = 2; end
            else    begin exp_code = 5'b01101; exp_req = "R5"; m_ph = 3; end
         2: if (en) begin
               if (tm) begin exp_code = err ? ref_spare(nib) : ref_data(nib); exp_req = "R8"; end
               else if (err) begin exp_code = 5'b00100; exp_req = "R7"; end
               else begin exp_code = ref_data(nib); exp_req = "R6"; end
            end else begin exp_code = 5'b01101; exp_req = "R5"; m_ph = 3; end
         default: begin exp_code = 5'b00111; exp_req = "R5"; m_ph = 0; end
      endcase
   endtask

   task automatic step(input bit en, input bit err, input logic [3:0] nib, input bit tm);
      @(negedge clk);
      if (have_exp) check(code_out, exp_code, exp_req);
      tx_en = en; tx_err = err; tx_nibble = nib; test_mode = tm;
      model(en, err, nib, tm);
      have_exp = 1'b1;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(8 * 190000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'hC0DE5));
      rst_n = 1'b0; tx_en = 1'b1; tx_err = 1'b1; tx_nibble = 4'h3; test_mode = 1'b1;
      repeat (3) @(negedge clk);
      check(code_out, 5'b11111, "R1");
      tx_en = 1'b0; tx_err = 1'b0; tx_nibble = 4'h0; test_mode = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1 check(code_out, 5'b11111, "R1");
      // R1: first cycle after reset with enable low stays idle
      step(0, 1, 4'hA, 1);
      // R2: garbage while idle
      step(0, 1, 4'h5, 0);
      step(0, 0, 4'hF, 1);
      // R4 with error on J and K cycles, R3 latency probe
      step(1, 1, 4'h7, 0);
      step(1, 1, 4'h5, 0);
      #3 check(code_out, 5'b11000, "R3");
      step(1, 0, 4'h0, 0);
      for (int n = 0; n < 16; n++) step(1, 0, 4'(n), 0);
      // R7 burst of errors
      for (int n = 0; n < 4; n++) step(1, 1, 4'(n), 0);
      step(0, 1, 4'h9, 0);
      step(0, 0, 4'h0, 0);
      step(0, 0, 4'h0, 0);
      // R5 one-nibble frame
      step(1, 0, 4'h1, 0);
      step(0, 0, 4'h1, 0);
      step(0, 0, 4'h1, 0);
      step(0, 0, 4'h1, 0);
      // R8 full sweep in test mode
      step(1, 0, 4'h0, 1);
      step(1, 0, 4'h0, 1);
      for (int v = 0; v < 32; v++) step(1, v[4], v[3:0], 1);
      // R5 enable rises in the R cycle
      step(0, 0, 4'h2, 1);
      step(1, 1, 4'h2, 1);
      step(1, 0, 4'h3, 0);
      step(1, 0, 4'h4, 0);
      step(1, 0, 4'h6, 0);
      step(0, 0, 4'h6, 0);
      step(0, 0, 4'h6, 0);
      // random frames
      for (int f = 0; f < 300; f++) begin
         bit tm;
         int len, gap;
         tm  = ($urandom % 4) == 0;
         len = 1 + ($urandom % 20);
         gap = 1 + ($urandom % 5);
         for (int i = 0; i < len; i++)
            step(1, ($urandom % 6) == 0, 4'($urandom), tm);
         for (int i = 0; i < gap; i++)
            step(0, $urandom % 2, 4'($urandom), $urandom % 2);
      end
      step(0, 0, 4'h0, 0);
      step(0, 0, 4'h0, 0);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule